// File: doc/BRIEF.md
# CEC Message Transmit Engine

This block sends one outgoing message of up to sixteen bytes onto a single-wire, open-drain consumer-electronics control line. Software fills a byte buffer (byte 0 is the header, byte 1 the opcode), writes the byte count minus one into a length register and then writes a command. The engine first waits for the line to stay released for a programmable signal-free time. It then sends a start bit and, for every byte, eight data bits MSB first, an end-of-message bit and an acknowledge slot. All pulse widths are counted on a slow tick (nominally 32768 Hz) that the surrounding chip supplies as a one-cycle enable.

A two-bit status output reports idle, busy, sent or failed. A sticky interrupt flag rises when a frame ends, whether it succeeded or failed. If another device holds the line low while this engine has released it, the frame backs off for the retry signal-free time and starts again, up to a bounded number of attempts.

Top module: `cec_tx_engine`

## Requirements
- R1: After reset the status is 0 (idle), the interrupt is low and the line is released.
- R2: A frame opens with a start bit driven low for 121 ticks and then released for 26 ticks.
- R3: Buffer addresses 0x00..0x0F hold the bytes and the length register (address 0x21) holds count minus one. Bytes 0..length are sent in order, each MSB first. A 1 bit is driven low for 20 ticks and then released for 59 ticks. A 0 bit is driven low for 49 ticks and then released for 29 ticks.
- R4: The ninth bit of each byte (end of message) is 1 on the last byte only and 0 on every other byte.
- R5: The acknowledge slot is driven low for 20 ticks and then released. The line is sampled 15 ticks after the release. For a directed header (low nibble not 0xF), a low level means acknowledged. A high level ends the frame with status 3.
- R6: For a broadcast header (low nibble 0xF), a high level at the sample point means accepted. A low level ends the frame with status 3.
- R7: Writing command 1 (address 0x20) sets status 1 until the frame ends. A frame whose last byte is acknowledged ends with status 2.
- R8: Each frame end sets the sticky interrupt. Writing 1 to bit 0 of address 0x22 clears it, and writing 0 there has no effect. When a frame ends in the same cycle as a clear, the set wins.
- R9: Command 2 releases the line on the next cycle and sets status 0, with no interrupt.
- R10: Command 0 changes neither the status nor the line.
- R11: Before the start bit, the line must be seen released for a continuous number of ticks. Command 1 uses the new-initiator count (address 0x29, reset 0x000). Command 3 uses the next-transfer count (address 0x2A, reset 0x2AA).
- R12: A low line 3 ticks after the engine released a non-acknowledge bit counts as a lost contention. The engine restarts the frame after the retry count (address 0x28, reset 0x118). The second loss in a frame ends it with status 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timing enable at the bit-timing rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 11 | Register write data (bytes use bits 7:0) |
| line_in | input | 1 | Sensed level of the shared line |
| line_drive_low | output | 1 | 1 pulls the shared line low |
| tx_status | output | 2 | 0 idle, 1 busy, 2 sent, 3 failed |
| tx_irq | output | 1 | Sticky frame-end interrupt |

## Verification
Two functions can fall in the same cycle: the frame-end update that raises the interrupt, and a software write that clears it. The bench holds the clear write active on every cycle across the end of a frame. Under a set-wins rule the interrupt must show high for exactly one cycle and then drop. A scoreboard decodes the pulse widths on the driven line and compares each decoded bit with the bits queued by the driver. A model of the remote device pulls the line during acknowledge slots or during a data bit to provoke nack, broadcast rejection and contention restarts.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

    typedef enum logic [1:0] {
        TXS_IDLE = 2'd0,
        TXS_BUSY = 2'd1,
        TXS_OK   = 2'd2,
        TXS_ERR  = 2'd3
    } txs_e;

    typedef enum logic [1:0] {
        TXC_NOP   = 2'd0,
        TXC_SEND  = 2'd1,
        TXC_ABORT = 2'd2,
        TXC_NEXT  = 2'd3
    } txc_e;

    typedef enum logic [1:0] {
        BK_START = 2'd0,
        BK_ONE   = 2'd1,
        BK_ZERO  = 2'd2,
        BK_ACK   = 2'd3
    } bk_e;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_FREE = 2'd1,
        FR_BIT  = 2'd2
    } fr_e;

    localparam logic [5:0] A_CMD     = 6'h20;
    localparam logic [5:0] A_LEN     = 6'h21;
    localparam logic [5:0] A_ICLR    = 6'h22;
    localparam logic [5:0] A_W_RETRY = 6'h28;
    localparam logic [5:0] A_W_NEWI  = 6'h29;
    localparam logic [5:0] A_W_NEXT  = 6'h2A;

endpackage

// File: rtl/cec_tx_regs.sv
module cec_tx_regs
    import cec_tx_pkg::*;
#(
    parameter int MSG_BYTES = 16,
    parameter int WAIT_W    = 11,
    parameter int RETRY_RST = 'h118,
    parameter int NEWI_RST  = 'h000,
    parameter int NEXT_RST  = 'h2AA,
    localparam int IDX_W    = $clog2(MSG_BYTES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [5:0]                     wr_addr,
    input  logic [WAIT_W-1:0]              wr_data,
    output logic [MSG_BYTES-1:0][7:0]      msg,
    output logic [IDX_W-1:0]               len,
    output logic [WAIT_W-1:0]              w_retry,
    output logic [WAIT_W-1:0]              w_newi,
    output logic [WAIT_W-1:0]              w_next,
    output logic                           cmd_stb,
    output txc_e                           cmd,
    output logic                           iclr_stb
);

    typedef struct packed {
        logic [MSG_BYTES-1:0][7:0] mem;
        logic [IDX_W-1:0]          len;
        logic [WAIT_W-1:0]         wr;
        logic [WAIT_W-1:0]         wn;
        logic [WAIT_W-1:0]         wx;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (int'(wr_addr) < MSG_BYTES) begin
                r_d.mem[wr_addr[IDX_W-1:0]] = wr_data[7:0];
            end else begin
                case (wr_addr)
                    A_LEN:     r_d.len = wr_data[IDX_W-1:0];
                    A_W_RETRY: r_d.wr  = wr_data;
                    A_W_NEWI:  r_d.wn  = wr_data;
                    A_W_NEXT:  r_d.wx  = wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.wr <= WAIT_W'(RETRY_RST);
            r_q.wn <= WAIT_W'(NEWI_RST);
            r_q.wx <= WAIT_W'(NEXT_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign msg      = r_q.mem;
    assign len      = r_q.len;
    assign w_retry  = r_q.wr;
    assign w_newi   = r_q.wn;
    assign w_next   = r_q.wx;
    assign cmd_stb  = wr_en && (wr_addr == A_CMD);
    assign cmd      = txc_e'(wr_data[1:0]);
    assign iclr_stb = wr_en && (wr_addr == A_ICLR) && wr_data[0];

    // R3: a length write lands in the length register on the next cycle
    a_r3_len_written: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_LEN) |=> (len == $past(wr_data[IDX_W-1:0])));

endmodule

// File: rtl/cec_tx_bitgen.sv
module cec_tx_bitgen
    import cec_tx_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int START_LO = 121,
    parameter int START_HI = 26,
    parameter int ONE_LO   = 20,
    parameter int ONE_HI   = 59,
    parameter int ZERO_LO  = 49,
    parameter int ZERO_HI  = 29,
    parameter int ACK_PT   = 15,
    parameter int CONT_PT  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic go,
    input  bk_e  kind,
    input  logic abort,
    input  logic line_in,
    output logic drive_low,
    output logic done,
    output logic lost,
    output logic ack_low
);

    typedef struct packed {
        logic             active;
        logic             hi;
        bk_e              kind;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             lost;
        logic             ack_low;
    } bit_t;

    bit_t s_d, s_q;
    logic [CNT_W-1:0] lo_len, hi_len, nxt;

    always_comb begin
        case (s_q.kind)
            BK_START: begin lo_len = CNT_W'(START_LO); hi_len = CNT_W'(START_HI); end
            BK_ZERO:  begin lo_len = CNT_W'(ZERO_LO);  hi_len = CNT_W'(ZERO_HI);  end
            default:  begin lo_len = CNT_W'(ONE_LO);   hi_len = CNT_W'(ONE_HI);   end
        endcase
        nxt = s_q.cnt + 1'b1;
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.lost = 1'b0;
        if (abort) begin
            s_d.active = 1'b0;
        end else if (!s_q.active) begin
            if (go) begin
                s_d.active  = 1'b1;
                s_d.hi      = 1'b0;
                s_d.kind    = kind;
                s_d.cnt     = '0;
                s_d.ack_low = 1'b0;
            end
        end else if (tick) begin
            if (!s_q.hi) begin
                if (nxt == lo_len) begin
                    s_d.hi  = 1'b1;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = nxt;
                end
            end else begin
                s_d.cnt = nxt;
                if (s_q.kind == BK_ACK && nxt == CNT_W'(ACK_PT)) begin
                    s_d.ack_low = !line_in;
                end
                if (s_q.kind != BK_ACK && nxt == CNT_W'(CONT_PT) && !line_in) begin
                    s_d.active = 1'b0;
                    s_d.lost   = 1'b1;
                end else if (nxt == hi_len) begin
                    s_d.active = 1'b0;
                    s_d.done   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign drive_low = s_q.active && !s_q.hi;
    assign done      = s_q.done;
    assign lost      = s_q.lost;
    assign ack_low   = s_q.ack_low;

    // R9: an abort frees the line and yields no bit completion
    a_r9_abort_frees: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!drive_low && !done));

    // R12: a lost contention leaves the line released
    a_r12_lost_released: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> !drive_low);

    // R5: a bit ends either normally or by contention, never both
    a_r5_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, lost}));

endmodule

// File: rtl/cec_tx_engine.sv
module cec_tx_engine
    import cec_tx_pkg::*;
#(
    parameter int MSG_BYTES = 16,
    parameter int WAIT_W    = 11,
    parameter int RETRY_MAX = 2,
    localparam int IDX_W    = $clog2(MSG_BYTES),
    localparam int TRY_W    = $clog2(RETRY_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [WAIT_W-1:0] wr_data,
    input  logic              line_in,
    output logic              line_drive_low,
    output logic [1:0]        tx_status,
    output logic              tx_irq
);

    localparam logic [3:0] ACK_POS = 4'd9;

    typedef struct packed {
        fr_e               fr;
        txs_e              st;
        logic              irq;
        logic [IDX_W-1:0]  byte_i;
        logic [3:0]        bit_i;
        logic              in_start;
        logic [WAIT_W-1:0] fcnt;
        logic [WAIT_W-1:0] flim;
        logic [TRY_W-1:0]  tries;
        logic              go;
        bk_e               kind;
    } eng_t;

    eng_t e_d, e_q;

    logic [MSG_BYTES-1:0][7:0] msg;
    logic [IDX_W-1:0]  len;
    logic [WAIT_W-1:0] w_retry, w_newi, w_next;
    logic cmd_stb, iclr_stb;
    txc_e cmd;
    logic done, lost, ack_low, bit_abort;
    logic fin, last, bcast, ack_ok;

    cec_tx_regs #(.MSG_BYTES(MSG_BYTES), .WAIT_W(WAIT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .msg(msg), .len(len), .w_retry(w_retry),
        .w_newi(w_newi), .w_next(w_next), .cmd_stb(cmd_stb), .cmd(cmd),
        .iclr_stb(iclr_stb)
    );

    assign bit_abort = cmd_stb && (cmd != TXC_NOP);

    cec_tx_bitgen u_bit (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(e_q.go), .kind(e_q.kind),
        .abort(bit_abort), .line_in(line_in), .drive_low(line_drive_low),
        .done(done), .lost(lost), .ack_low(ack_low)
    );

    function automatic bk_e kind_of(logic [7:0] b, logic [3:0] pos, logic eom);
        if (!pos[3])              return b[~pos[2:0]] ? BK_ONE : BK_ZERO;
        else if (pos == 4'd8)     return eom ? BK_ONE : BK_ZERO;
        else                      return BK_ACK;
    endfunction

    always_comb begin
        e_d    = e_q;
        e_d.go = 1'b0;
        fin    = 1'b0;
        last   = (e_q.byte_i == len);
        bcast  = (msg[0][3:0] == 4'hF);
        ack_ok = bcast ? !ack_low : ack_low;
        if (iclr_stb) e_d.irq = 1'b0;
        if (bit_abort) begin
            e_d.in_start = 1'b0;
            if (cmd == TXC_ABORT) begin
                e_d.fr = FR_IDLE;
                e_d.st = TXS_IDLE;
            end else begin
                e_d.fr    = FR_FREE;
                e_d.st    = TXS_BUSY;
                e_d.fcnt  = '0;
                e_d.tries = '0;
                e_d.flim  = (cmd == TXC_SEND) ? w_newi : w_next;
            end
        end else begin
            case (e_q.fr)
                FR_FREE: begin
                    if (line_in && e_q.fcnt >= e_q.flim) begin
                        e_d.fr       = FR_BIT;
                        e_d.go       = 1'b1;
                        e_d.kind     = BK_START;
                        e_d.in_start = 1'b1;
                        e_d.byte_i   = '0;
                        e_d.bit_i    = '0;
                    end else if (!line_in) begin
                        e_d.fcnt = '0;
                    end else if (tick) begin
                        e_d.fcnt = e_q.fcnt + 1'b1;
                    end
                end
                FR_BIT: begin
                    if (lost) begin
                        if (int'(e_q.tries) + 1 >= RETRY_MAX) begin
                            e_d.fr = FR_IDLE;
                            e_d.st = TXS_ERR;
                            fin    = 1'b1;
                        end else begin
                            e_d.tries = e_q.tries + 1'b1;
                            e_d.fr    = FR_FREE;
                            e_d.fcnt  = '0;
                            e_d.flim  = w_retry;
                        end
                    end else if (done) begin
                        if (e_q.in_start) begin
                            e_d.in_start = 1'b0;
                            e_d.go       = 1'b1;
                            e_d.kind     = kind_of(msg[e_q.byte_i], 4'd0, last);
                        end else if (e_q.bit_i == ACK_POS) begin
                            if (!ack_ok) begin
                                e_d.fr = FR_IDLE;
                                e_d.st = TXS_ERR;
                                fin    = 1'b1;
                            end else if (last) begin
                                e_d.fr = FR_IDLE;
                                e_d.st = TXS_OK;
                                fin    = 1'b1;
                            end else begin
                                e_d.byte_i = e_q.byte_i + 1'b1;
                                e_d.bit_i  = '0;
                                e_d.go     = 1'b1;
                                e_d.kind   = kind_of(msg[e_d.byte_i], 4'd0, e_d.byte_i == len);
                            end
                        end else begin
                            e_d.bit_i = e_q.bit_i + 1'b1;
                            e_d.go    = 1'b1;
                            e_d.kind  = kind_of(msg[e_q.byte_i], e_d.bit_i, last);
                        end
                    end
                end
                default: ;
            endcase
        end
        if (fin) e_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign tx_status = e_q.st;
    assign tx_irq    = e_q.irq;

    // R7: status reads busy whenever a frame is in progress
    a_r7_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.fr != FR_IDLE) |-> (tx_status == 2'd1));

    // R8: interrupt stays set until a clear write
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !iclr_stb) |=> tx_irq);

    // R8: a frame end always raises the interrupt, clear or not
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> tx_irq);

    // R10: a no-op command leaves an idle engine's status alone
    a_r10_nop_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd == TXC_NOP && e_q.fr == FR_IDLE) |=> $stable(tx_status));

    // R11: the line is never pulled during the signal-free wait
    a_r11_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.fr == FR_FREE) |-> !line_drive_low);

endmodule

// File: tb/tb_cec_tx_engine.sv
module tb_cec_tx_engine;
    import cec_tx_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [10:0] wr_data = '0;
    logic ext_low = 1'b0;
    logic line, drv, irq;
    logic [1:0] st;

    always #5 clk = ~clk;
    always @(posedge clk) tick <= ~tick;
    assign line = ~(drv | ext_low);

    cec_tx_engine dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_in(line), .line_drive_low(drv),
        .tx_status(st), .tx_irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    bit exp_q[$];
    bit ack_q[$];
    int exp_idx = 0, starts = 0, pos = -1, lo_cnt = 0, hi_cnt = 0;
    int ext_cnt = 0, cont_mode = 0, irq_hi = 0;
    bit drv_prev = 0, after_start = 0, mon_off = 0, b_act = 0, b_exp = 0;

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 11'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input byte unsigned b[], input bit acks[]);
        mon_off = 1'b0;
        exp_q.delete(); ack_q.delete();
        for (int i = 0; i < b.size(); i++) begin
            wr(6'(i), b[i]);
            for (int k = 7; k >= 0; k--) exp_q.push_back(b[i][k]);
            exp_q.push_back(i == b.size() - 1);
            ack_q.push_back(acks[i]);
        end
        wr(A_LEN, b.size() - 1);
    endtask

    task automatic wait_done();
        int k = 0;
        @(negedge clk);
        while (st == 2'(TXS_BUSY) && k < 60000) begin
            @(negedge clk);
            k++;
        end
        repeat (100) @(negedge clk);
    endtask

    // monitor / scoreboard: decode pulse widths and compare with the queue
    always @(negedge clk) begin
        if (!rst_n) begin
            drv_prev = 1'b0; lo_cnt = 0; hi_cnt = 0; pos = -1;
        end else begin
            if (tick) begin
                if (drv) lo_cnt++; else hi_cnt++;
                if (ext_cnt > 0) begin
                    ext_cnt--;
                    if (ext_cnt == 0) ext_low = 1'b0;
                end
            end
            if (irq) irq_hi++;
            if (drv && !drv_prev) begin
                if (after_start) begin
                    check(hi_cnt >= 26 && hi_cnt <= 27, "R2 start high time", hi_cnt, 26);
                    after_start = 1'b0;
                end
                hi_cnt = 0;
            end
            if (!drv && drv_prev) begin
                if (mon_off) begin
                    pos = -1;
                end else if (lo_cnt > 100) begin
                    starts++;
                    check(lo_cnt == 121, "R2 start low time", lo_cnt, 121);
                    after_start = 1'b1; pos = 0; exp_idx = 0;
                end else if (pos == 9) begin
                    check(lo_cnt == 20, "R5 ack slot low time", lo_cnt, 20);
                    if (ack_q.size() > 0 && ack_q.pop_front()) begin
                        ext_low = 1'b1; ext_cnt = 30;
                    end
                    pos = 0;
                end else if (pos >= 0) begin
                    b_act = (lo_cnt < 35);
                    b_exp = (exp_idx < exp_q.size()) ? exp_q[exp_idx] : ~b_act;
                    check(lo_cnt == 20 || lo_cnt == 49, "R3 bit low time", lo_cnt, b_exp ? 20 : 49);
                    if (pos == 8) check(b_act == b_exp, "R4 end-of-message bit", b_act, b_exp);
                    else          check(b_act == b_exp, "R3 data bit", b_act, b_exp);
                    exp_idx++;
                    if (pos == 0 && exp_idx == 1 && cont_mode != 0) begin
                        ext_low = 1'b1; ext_cnt = 6;
                        if (cont_mode == 1) cont_mode = 0;
                    end
                    pos++;
                end
                lo_cnt = 0;
            end
            drv_prev = drv;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int t;
        byte unsigned big[];
        bit bigack[];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(st == 2'd0, "R1 reset status", st, 0);
        check(irq == 1'b0, "R1 reset irq", irq, 0);
        check(drv == 1'b0, "R1 reset line", drv, 0);

        // directed two-byte frame, both acked
        load('{8'h04, 8'h8F}, '{1'b1, 1'b1});
        wr(A_CMD, 1);
        check(st == 2'd1, "R7 busy after send", st, 1);
        wait_done();
        check(st == 2'd2, "R7 sent status", st, 2);
        check(irq == 1'b1, "R8 irq on end", irq, 1);
        check(exp_idx == 18, "R3 bit count", exp_idx, 18);
        check(starts == 1, "R2 one start", starts, 1);

        // write-one-to-clear
        wr(A_ICLR, 0);
        check(irq == 1'b1, "R8 zero write ignored", irq, 1);
        wr(A_ICLR, 1);
        check(irq == 1'b0, "R8 clear", irq, 0);

        // no-op command
        wr(A_CMD, 0);
        repeat (300) @(negedge clk);
        check(st == 2'd2, "R10 nop status", st, 2);
        check(starts == 1, "R10 nop no frame", starts, 1);

        // broadcast accepted (nobody pulls) and rejected (someone pulls)
        load('{8'h4F}, '{1'b0});
        wr(A_CMD, 1);
        wait_done();
        check(st == 2'd2, "R6 broadcast accepted", st, 2);
        load('{8'h4F}, '{1'b1});
        wr(A_CMD, 1);
        wait_done();
        check(st == 2'd3, "R6 broadcast rejected", st, 3);

        // directed nack on second byte
        wr(A_ICLR, 1);
        load('{8'h10, 8'h44, 8'hA5}, '{1'b1, 1'b0, 1'b1});
        wr(A_CMD, 1);
        wait_done();
        check(st == 2'd3, "R5 nack error", st, 3);
        check(exp_idx == 18, "R5 stops after nacked byte", exp_idx, 18);
        check(irq == 1'b1, "R8 irq on error", irq, 1);

        // signal-free waits
        wr(A_W_NEWI, 40);
        load('{8'h01}, '{1'b1});
        wr(A_CMD, 1);
        t = 0;
        while (!drv) begin
            if (tick) t++;
            @(negedge clk);
        end
        check(t >= 40 && t <= 42, "R11 new-initiator wait", t, 40);
        wait_done();
        wr(A_W_NEXT, 60);
        load('{8'h02}, '{1'b1});
        wr(A_CMD, 3);
        t = 0;
        while (!drv) begin
            if (tick) t++;
            @(negedge clk);
        end
        check(t >= 60 && t <= 62, "R11 next-transfer wait", t, 60);
        wait_done();
        check(st == 2'd2, "R11 frame after wait", st, 2);
        wr(A_W_NEWI, 0);

        // full-length frame
        big = new[16];
        bigack = new[16];
        foreach (big[i]) begin
            big[i] = 8'(i * 37 + 5);
            bigack[i] = 1'b1;
        end
        load(big, bigack);
        wr(A_CMD, 1);
        wait_done();
        check(st == 2'd2, "R3 sixteen bytes sent", st, 2);
        check(exp_idx == 144, "R3 sixteen byte bit count", exp_idx, 144);

        // contention once: restart then success
        wr(A_W_RETRY, 5);
        starts = 0;
        cont_mode = 1;
        load('{8'h05, 8'h36}, '{1'b1, 1'b1});
        wr(A_CMD, 1);
        wait_done();
        check(starts == 2, "R12 restart after loss", starts, 2);
        check(st == 2'd2, "R12 success after retry", st, 2);

        // contention on every attempt
        starts = 0;
        cont_mode = 2;
        load('{8'h05}, '{1'b1});
        wr(A_CMD, 1);
        wait_done();
        cont_mode = 0;
        check(starts == 2, "R12 attempts before error", starts, 2);
        check(st == 2'd3, "R12 error after second loss", st, 3);

        // end of frame and clear write in the same cycle
        wr(A_ICLR, 1);
        load('{8'h03}, '{1'b1});
        wr(A_CMD, 1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_ICLR; wr_data = 11'd1;
        irq_hi = 0;
        wait_done();
        wr_en = 1'b0;
        check(irq_hi == 1, "R8 set beats clear", irq_hi, 1);
        check(irq == 1'b0, "R8 cleared afterwards", irq, 0);
        check(st == 2'd2, "R7 status with clear held", st, 2);

        // abort mid-frame
        starts = 0;
        load('{8'h08, 8'hC3}, '{1'b1, 1'b1});
        wr(A_CMD, 1);
        while (exp_idx < 3) @(negedge clk);
        mon_off = 1'b1;
        wr(A_CMD, 2);
        check(drv == 1'b0, "R9 line released", drv, 0);
        check(st == 2'd0, "R9 idle after abort", st, 0);
        repeat (500) @(negedge clk);
        check(irq == 1'b0, "R9 no irq on abort", irq, 0);
        check(drv == 1'b0, "R9 line stays released", drv, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule